// File: doc/BRIEF.md
# Byte-Serial Absolute Jump Fetch Sequencer

This block is the program counter and instruction fetch sequencer of a small CPU with an 8-bit data path and a 16-bit address space. Each clock it puts one address on the bus and takes one byte back. It recognises one instruction, a three-byte absolute jump, and treats every other opcode as a single-byte no-operation. Because only one byte can arrive per clock, the two target bytes of a jump come in on separate cycles.

The target is assembled without a 16-bit holding register. The low target byte is parked in an 8-bit operand buffer. The high target byte is then fetched from the sequentially advanced old counter, which is still intact. Both counter halves are replaced at the closing edge of that third cycle: the low half from the buffer and the high half straight from the bus. The next opcode fetch uses the new counter.

The sequencer is meant to sit in front of a memory that returns the byte for the presented address within the same cycle. A sync strobe marks every cycle in which the bus carries an opcode address.

Top module: `absjmp_fetch_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the counter loads `RESET_PC` (default 0x0200) and the sequencer enters opcode fetch. In the cycle after that edge, `mem_addr` equals `RESET_PC` and `sync` is 1. A reset asserted in the middle of a jump abandons that jump.
- R2: `mem_rdata` is taken at the end of the same cycle in which its address is on `mem_addr`. No wait cycles exist.
- R3: An opcode byte other than 0x4C (for example 0xEA, 0x4D, 0xCC, 0x0C) advances the address by exactly one. The next cycle is again an opcode fetch with `sync` = 1.
- R4: When an opcode fetch at address A returns 0x4C, the next two cycles present A+1 and then A+2, with `sync` = 0 in both.
- R5: The low target byte read at A+1 does not affect the bus before the jump completes. The address in the third jump cycle is A+2 whatever that byte is.
- R6: The cycle that follows the third jump cycle presents {high byte read at A+2, low byte read at A+1} with `sync` = 1. A jump therefore occupies exactly three cycles.
- R7: Advancing the address carries from the low byte into the high byte. This holds when the operand bytes of a jump straddle a 256-byte page boundary (opcode at xxFE or xxFF).
- R8: `pc` always equals `mem_addr`.
- R9: Advancing from 0xFFFF wraps to 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| mem_rdata | input | DATA_W (8) | Byte returned by memory for the current `mem_addr` |
| mem_addr | output | 2*DATA_W (16) | Registered address bus |
| sync | output | 1 | High in cycles that fetch an opcode |
| pc | output | 2*DATA_W (16) | Current program counter |

## Verification
The bench targets jumps whose low target byte differs from the low byte of A+2. If the counter low half were written one cycle early, the third jump cycle would fetch from the wrong address and the high target byte would be wrong. Jumps with the opcode at xxFE and xxFF check the carry into the high half; a design that lost the carry would fetch an operand from the wrong page. A stretch of no-operation opcodes running through 0xFFFF checks wraparound. A run of near-miss opcode values checks that only 0x4C starts a jump. A reset asserted mid-jump checks that no stale operand state survives.

// File: rtl/absjmp_pkg.sv
package absjmp_pkg;

  typedef enum logic [1:0] {
    ST_OPC = 2'd0,
    ST_ADL = 2'd1,
    ST_ADH = 2'd2
  } fetch_state_e;

  localparam int NUM_HALVES = 2;

endpackage

// File: rtl/absjmp_ctrl.sv
module absjmp_ctrl
  import absjmp_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         opc_is_jump,
  output fetch_state_e state,
  output logic         sync
);

  fetch_state_e nxt;

  always_comb begin
    nxt = ST_OPC;
    unique case (state)
      ST_OPC:  nxt = opc_is_jump ? ST_ADL : ST_OPC;
      ST_ADL:  nxt = ST_ADH;
      ST_ADH:  nxt = ST_OPC;
      default: nxt = ST_OPC;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_OPC;
      sync  <= 1'b1;
    end else begin
      state <= nxt;
      sync  <= (nxt == ST_OPC);
    end
  end

  assert_adl_to_adh_R4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ADL) |=> (state == ST_ADH));

  assert_adh_to_opc_R6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ADH) |=> (state == ST_OPC && sync));

endmodule

// File: rtl/absjmp_opbuf.sv
module absjmp_opbuf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);

  always_ff @(posedge clk) begin
    if (rst)          dout <= '0;
    else if (capture) dout <= din;
  end

  assert_buf_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !$past(capture) && !$past(rst) |-> $stable(dout));

  assert_buf_take_R2: assert property (@(posedge clk) disable iff (rst)
    capture |=> (dout == $past(din)));

endmodule

// File: rtl/absjmp_pc_byte.sv
module absjmp_pc_byte #(
  parameter int              DATA_W    = 8,
  parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cin,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  output logic [DATA_W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)       q <= RESET_VAL;
    else if (load) q <= load_val;
    else if (cin)  q <= q + DATA_W'(1);
  end

endmodule

// File: rtl/absjmp_fetch_seq.sv
module absjmp_fetch_seq
  import absjmp_pkg::*;
#(
  parameter int                  DATA_W     = 8,
  parameter logic [2*DATA_W-1:0] RESET_PC   = 'h0200,
  parameter logic [DATA_W-1:0]   JMP_OPCODE = 'h4C
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [DATA_W-1:0]   mem_rdata,
  output logic [2*DATA_W-1:0] mem_addr,
  output logic                sync,
  output logic [2*DATA_W-1:0] pc
);

  localparam int ADDR_W = NUM_HALVES * DATA_W;

  fetch_state_e      state;
  logic              opc_is_jump;
  logic              step;
  logic              load_pc;
  logic [DATA_W-1:0] buf_q;
  logic [DATA_W-1:0] half_q [NUM_HALVES];

  assign opc_is_jump = (state == ST_OPC) && (mem_rdata == JMP_OPCODE);
  assign step        = (state != ST_ADH);
  assign load_pc     = (state == ST_ADH);

  absjmp_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .opc_is_jump (opc_is_jump),
    .state       (state),
    .sync        (sync)
  );

  absjmp_opbuf #(.DATA_W(DATA_W)) u_opbuf (
    .clk     (clk),
    .rst     (rst),
    .capture (state == ST_ADL),
    .din     (mem_rdata),
    .dout    (buf_q)
  );

  for (genvar g = 0; g < NUM_HALVES; g++) begin : g_half
    logic              cin;
    logic [DATA_W-1:0] src;
    if (g == 0) begin : g_lo
      assign cin = step;
      assign src = buf_q;
    end else begin : g_hi
      assign cin = step && (&half_q[0]);
      assign src = mem_rdata;
    end
    absjmp_pc_byte #(
      .DATA_W    (DATA_W),
      .RESET_VAL (RESET_PC[g*DATA_W +: DATA_W])
    ) u_byte (
      .clk      (clk),
      .rst      (rst),
      .cin      (cin),
      .load     (load_pc),
      .load_val (src),
      .q        (half_q[g])
    );
    assign pc[g*DATA_W +: DATA_W] = half_q[g];
  end

  assign mem_addr = pc;

  assert_reset_pc_R1: assert property (@(posedge clk)
    $past(rst) |-> (mem_addr == RESET_PC && sync));

  assert_nop_step_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(state == ST_OPC && mem_rdata != JMP_OPCODE) && !$past(rst))
      |-> (mem_addr == ADDR_W'($past(mem_addr) + ADDR_W'(1)) && sync));

  assert_operand_seq_R4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ADL || state == ST_ADH)
      |-> (mem_addr == ADDR_W'($past(mem_addr) + ADDR_W'(1)) && !sync));

  assert_jump_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    opc_is_jump |=> !sync);

  assert_target_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(state == ST_ADH) && !$past(rst))
      |-> (mem_addr == {$past(mem_rdata), $past(buf_q)}));

endmodule

// File: tb/absjmp_fetch_seq_tb_top.sv
module absjmp_fetch_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NV         = 6;
  localparam logic [15:0] CHAIN [NV] = '{
    16'h0200, 16'h03FE, 16'h0AFF, 16'h0510, 16'h0F40, 16'hFFFE
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  mem_rdata;
  logic [15:0] mem_addr;
  logic        sync;
  logic [15:0] pc;
  logic [7:0]  mem [4096];
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign mem_rdata = mem[mem_addr[11:0]];

  absjmp_fetch_seq dut_i (
    .clk       (clk),
    .rst       (rst),
    .mem_rdata (mem_rdata),
    .mem_addr  (mem_addr),
    .sync      (sync),
    .pc        (pc)
  );

  task automatic chk(input string req, input logic [15:0] exp_a, input logic exp_s);
    n_chk++;
    if (mem_addr !== exp_a || sync !== exp_s) begin
      n_bad++;
      $display("FAIL %s: addr=%h sync=%b expected addr=%h sync=%b",
               req, mem_addr, sync, exp_a, exp_s);
    end
    n_chk++;
    if (pc !== mem_addr) begin
      n_bad++;
      $display("FAIL R8: pc=%h expected %h", pc, mem_addr);
    end
  endtask

  task automatic put(input logic [15:0] a, input logic [7:0] d);
    mem[a[11:0]] = d;
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 8'hEA;
    for (int i = 0; i < NV - 1; i++) begin
      put(CHAIN[i], 8'h4C);
      put(CHAIN[i] + 16'd1, CHAIN[i+1][7:0]);
      put(CHAIN[i] + 16'd2, CHAIN[i+1][15:8]);
    end
    put(16'h0000, 8'h4D);
    put(16'h0001, 8'hCC);
    put(16'h0002, 8'h0C);
    put(16'h0003, 8'h4C);
    put(16'h0004, 8'h00);
    put(16'h0005, 8'h02);

    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1 reset", 16'h0200, 1'b1);
    rst = 1'b0;

    // chained jumps: early-write traps (R5) and page crossings (R7)
    for (int i = 0; i < NV - 1; i++) begin
      chk("R4 opcode", CHAIN[i], 1'b1);
      @(negedge clk);
      chk("R4 low operand R2", CHAIN[i] + 16'd1, 1'b0);
      @(negedge clk);
      chk("R5 R7 high operand", CHAIN[i] + 16'd2, 1'b0);
      @(negedge clk);
    end
    chk("R6 target", 16'hFFFE, 1'b1);
    @(negedge clk);
    chk("R3 nop", 16'hFFFF, 1'b1);
    @(negedge clk);
    chk("R9 wrap", 16'h0000, 1'b1);
    @(negedge clk);
    chk("R3 near-miss 4D", 16'h0001, 1'b1);
    @(negedge clk);
    chk("R3 near-miss CC", 16'h0002, 1'b1);
    @(negedge clk);
    chk("R3 near-miss 0C", 16'h0003, 1'b1);
    @(negedge clk);
    chk("R4 R5 operand lo", 16'h0004, 1'b0);
    @(negedge clk);
    chk("R5 operand hi", 16'h0005, 1'b0);
    @(negedge clk);
    chk("R6 back to start", 16'h0200, 1'b1);
    @(negedge clk);
    chk("R4 mid-jump", 16'h0201, 1'b0);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 mid-jump reset", 16'h0200, 1'b1);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 restart operand", 16'h0201, 1'b0);
    @(negedge clk);
    chk("R1 restart high", 16'h0202, 1'b0);
    @(negedge clk);
    chk("R6 restart target", 16'h03FE, 1'b1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule